// File: doc/BRIEF.md
# Vector Immediate Logic and Shuffle Unit

This unit is one execution stage of a 128-bit vector datapath. Each accepted request carries a source vector, the current contents of the destination vector, an 8-bit immediate and an operation code. The unit returns a result vector that the surrounding pipeline writes back to the destination.

There are two groups of operations. The lane-wise group treats the vector as sixteen byte lanes and combines each lane with the same immediate byte. It covers the four plain logic operations and three bit-merge operations, and the bit-merge operations also read the old destination. The shuffle group splits the vector into groups of four elements, with elements of 8, 16 or 32 bits. In each group it rearranges the elements using four 2-bit selectors taken from the immediate.

An operation code that is not defined returns the old destination unchanged and raises an illegal flag together with the result. The result, the valid flag and the illegal flag are all registered and appear one clock after the request.

Top module: `vimm_lsu`

## Requirements
- R1: A synchronous active-high reset clears `out_valid` and `out_illegal`. The pair `out_valid` and `out_illegal` are registered copies of `in_valid` and of the illegal-code decision, and they appear on the first rising edge after the request.
- R2: Codes 0, 1, 2 and 3 produce, in every byte lane, src&imm, src|imm, ~(src|imm) and src^imm respectively.
- R3: Code 4 (insert where the immediate bit is set) produces, per byte, (src&imm)|(dst&~imm).
- R4: Code 5 (insert where the immediate bit is clear) produces, per byte, (src&~imm)|(dst&imm).
- R5: Code 6 (select) produces, per byte, (src&~dst)|(dst&imm).
- R6: Code 7 shuffles 8-bit elements. Element e is bits [8e+7:8e], and there are 16 elements in four groups of four. Output element at position j of a group equals the source element at position imm[2j+1:2j] of the same group.
- R7: Code 8 applies the same shuffle to 16-bit elements (8 elements, two groups). Code 9 applies it to 32-bit elements (4 elements, one group). An immediate of 0x1B reverses every group, and 0xE4 returns the source unchanged.
- R8: Codes 10 to 15 return dst unchanged and set `out_illegal`. For codes 0 to 9, `out_illegal` is 0.
- R9: While `in_valid` is 0, `out_data` and `out_illegal` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 4 | Operation code |
| in_imm | input | 8 | Immediate byte |
| in_src | input | 128 | Source vector |
| in_dst | input | 128 | Old destination vector |
| out_valid | output | 1 | Result valid, one clock after the request |
| out_illegal | output | 1 | Operation code was not defined |
| out_data | output | 128 | Result vector |

## Verification
Every result, together with its valid and illegal flags, is due on the first rising edge after the edge that samples the request. The bench drives the inputs on the falling edge and samples the outputs on the next falling edge, half a cycle after the result has been registered. The hold behaviour is checked by idling `in_valid` with changed inputs and confirming that the outputs stay the same.

// File: rtl/vimm_lsu.sv
module vimm_lsu #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   in_op,
  input  logic [7:0]   in_imm,
  input  logic [W-1:0] in_src,
  input  logic [W-1:0] in_dst,
  output logic         out_valid,
  output logic         out_illegal,
  output logic [W-1:0] out_data
);
  localparam int NB = W / 8;
  localparam int NH = W / 16;
  localparam int NW = W / 32;

  logic [W-1:0] imm_v, shf_b, shf_h, shf_w, res;
  logic         bad;

  assign imm_v = {NB{in_imm}};

  for (genvar e = 0; e < NB; e++) begin : g_b
    localparam int B = e - (e % 4);
    assign shf_b[8*e +: 8] = in_src[8*(B + in_imm[2*(e%4) +: 2]) +: 8];
  end
  for (genvar e = 0; e < NH; e++) begin : g_h
    localparam int B = e - (e % 4);
    assign shf_h[16*e +: 16] = in_src[16*(B + in_imm[2*(e%4) +: 2]) +: 16];
  end
  for (genvar e = 0; e < NW; e++) begin : g_w
    localparam int B = e - (e % 4);
    assign shf_w[32*e +: 32] = in_src[32*(B + in_imm[2*(e%4) +: 2]) +: 32];
  end

  always_comb begin
    bad = 1'b0;
    case (in_op)
      4'd0: res = in_src & imm_v;
      4'd1: res = in_src | imm_v;
      4'd2: res = ~(in_src | imm_v);
      4'd3: res = in_src ^ imm_v;
      4'd4: res = (in_src & imm_v) | (in_dst & ~imm_v);
      4'd5: res = (in_src & ~imm_v) | (in_dst & imm_v);
      4'd6: res = (in_src & ~in_dst) | (in_dst & imm_v);
      4'd7: res = shf_b;
      4'd8: res = shf_h;
      4'd9: res = shf_w;
      default: begin
        res = in_dst;
        bad = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_illegal <= bad;
    end
    if (in_valid) out_data <= res;
  end

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_clears_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_illegal_passthru_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op > 4'd9) |=> (out_illegal && out_data == $past(in_dst)));
  p_legal_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op <= 4'd9) |=> !out_illegal);
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_data) && $stable(out_illegal)));
  p_and_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd0) |=> ((out_data & ~{NB{$past(in_imm)}}) == '0));
  p_or_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == 4'd1) |=> ((out_data & {NB{$past(in_imm)}}) == {NB{$past(in_imm)}}));
endmodule

// File: tb/vimm_lsu_tb.sv
module vimm_lsu_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [3:0] in_op = '0;
  logic [7:0] in_imm = '0;
  logic [127:0] in_src = '0, in_dst = '0;
  logic out_valid, out_illegal;
  logic [127:0] out_data;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  vimm_lsu u_dut (.*);

  function automatic logic [127:0] model(input logic [3:0] op, input logic [7:0] im,
                                         input logic [127:0] s, input logic [127:0] d);
    logic [127:0] r;
    int sz;
    r = d;
    if (op <= 4'd6) begin
      for (int b = 0; b < 16; b++) begin
        logic [7:0] x, y, z;
        x = s[8*b +: 8]; y = d[8*b +: 8];
        case (op)
          4'd0: z = x & im;
          4'd1: z = x | im;
          4'd2: z = ~(x | im);
          4'd3: z = x ^ im;
          4'd4: z = (x & im) | (y & ~im);
          4'd5: z = (x & ~im) | (y & im);
          default: z = (x & ~y) | (y & im);
        endcase
        r[8*b +: 8] = z;
      end
    end else if (op <= 4'd9) begin
      sz = (op == 4'd7) ? 1 : (op == 4'd8) ? 2 : 4;
      for (int e = 0; e < 16 / sz; e++) begin
        int src_e;
        src_e = (e / 4) * 4 + int'((im >> (2 * (e % 4))) & 8'h3);
        for (int k = 0; k < 8 * sz; k++) r[8*sz*e + k] = s[8*sz*src_e + k];
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [7:0] im,
                     input logic [127:0] s, input logic [127:0] d);
    string rq;
    in_valid = 1'b1; in_op = op; in_imm = im; in_src = s; in_dst = d;
    @(negedge clk);
    in_valid = 1'b0;
    case (op)
      4'd0, 4'd1, 4'd2, 4'd3: rq = "R2";
      4'd4: rq = "R3";
      4'd5: rq = "R4";
      4'd6: rq = "R5";
      4'd7: rq = "R6";
      4'd8, 4'd9: rq = "R7";
      default: rq = "R8";
    endcase
    check(rq, out_data, model(op, im, s, d));
    check("R8 illegal", {127'd0, out_illegal}, {127'd0, op > 4'd9});
    check("R1 valid", {127'd0, out_valid}, 128'd1);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #20000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] seq, held;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) seq[8*i +: 8] = 8'(i);
    repeat (2) @(negedge clk);
    check("R1 reset valid", {127'd0, out_valid}, 128'd0);
    check("R1 reset illegal", {127'd0, out_illegal}, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    for (int op = 0; op < 16; op++) begin
      run(4'(op), 8'h00, rnd128(), rnd128());
      run(4'(op), 8'hFF, rnd128(), rnd128());
      run(4'(op), 8'h1B, seq, rnd128());
      run(4'(op), 8'hE4, rnd128(), rnd128());
    end
    run(4'd7, 8'h1B, seq, '0);
    check("R7 reverse bytes", out_data, 128'h0c0d0e0f_08090a0b_04050607_00010203);
    run(4'd9, 8'hE4, seq, '0);
    check("R7 identity word", out_data, seq);
    run(4'd15, 8'h5A, seq, ~seq);
    held = out_data;
    in_src = rnd128(); in_dst = rnd128(); in_op = 4'd3;
    @(negedge clk);
    check("R9 hold data", out_data, held);
    check("R9 hold illegal", {127'd0, out_illegal}, 128'd1);
    check("R1 idle valid", {127'd0, out_valid}, 128'd0);
    for (int i = 0; i < 500; i++)
      run(4'($urandom_range(0, 15)), 8'($urandom), rnd128(), rnd128());
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule